// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the rename stage of an out-of-order pipeline. Each cycle it may accept one instruction. The instruction carries two source architectural register numbers and one destination architectural register number. The source numbers are translated through a map table into the physical registers that currently hold the architected values. The destination is given a fresh physical register taken from a pool of unused ones. The map entry for the destination is then pointed at that fresh register. Every write therefore creates a new instance of the register, which removes write-after-read and write-after-write conflicts between instructions in flight.

The physical register that the destination mapped to before the rename is reported as the "old" physical ID. Downstream logic keeps it until every instruction that may still read it has completed, and also until the renaming instruction itself retires. At that point it hands the ID back on the release port, and the block returns it to the pool. The pool is a bitmap held inside the block. When it is empty, rename stalls and produces no output.

Results are registered: an instruction presented at one clock edge shows its renamed IDs on the outputs after that edge.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers 8 to 15 are free, and `out_valid` is low.
- R2: For an accepted instruction, `src1_phys` and `src2_phys` equal the map entries of `src1_arch` and `src2_arch`, and `out_valid` is high in the cycle after the instruction is presented.
- R3: An accepted instruction receives the lowest-numbered free physical register as `dst_phys`. That register leaves the pool, and the map entry of `dst_arch` is set to it, so a later instruction reading that architectural register gets `dst_phys`.
- R4: `old_phys` equals the physical register that `dst_arch` mapped to just before the instruction was renamed.
- R5: Sources are looked up before the same instruction updates the map. When a source equals the destination, that source's physical ID is the older instance, which is equal to `old_phys`.
- R6: When `in_valid` is high and the pool is empty, the instruction is not accepted: `out_valid` is low on the next cycle and the map is unchanged.
- R7: A release of a physical register that is neither free nor mapped returns it to the pool. The register can be allocated from the next cycle on.
- R8: A release and an allocation in the same cycle both take effect. The allocation chooses from the pool as it stood before the release.
- R9: A release naming a register that is currently mapped by some architectural register, or that is already free, has no effect on the pool.
- R10: When `in_valid` is low, `out_valid` is low on the next cycle and the map and pool are unchanged, whatever the architectural ID inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented for renaming |
| src1_arch | input | 3 | First source architectural register |
| src2_arch | input | 3 | Second source architectural register |
| dst_arch | input | 3 | Destination architectural register |
| rel_valid | input | 1 | Release request is valid |
| rel_phys | input | 4 | Physical register being released |
| out_valid | output | 1 | Renamed instruction available |
| src1_phys | output | 4 | Physical ID for the first source |
| src2_phys | output | 4 | Physical ID for the second source |
| dst_phys | output | 4 | Newly allocated physical destination |
| old_phys | output | 4 | Physical ID previously mapped to the destination |

## Verification
The bench builds the block with its default sizes: 8 architectural and 16 physical registers. With these sizes only eight spare registers exist, so the pool runs dry after eight renames. That brings stalls, a release into an empty pool, and a release racing an allocation within reach in a few dozen cycles. The random phase keeps the pool hovering near empty. It mixes legal releases of retired IDs with illegal releases of mapped IDs, so that every corner of the release filter is exercised while the map keeps shifting.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int unsigned RN_ARCH_REGS = 8;
    parameter int unsigned RN_PHYS_REGS = 16;
endpackage

// File: rtl/rn_free_pick.sv
// Priority picker: lowest-numbered set bit of the free bitmap.
module rn_free_pick #(
    parameter  int unsigned N = 16,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/rn_map_read.sv
// One read port into the rename map table.
module rn_map_read #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned AW      = 3,
    parameter int unsigned DW      = 4
) (
    input  logic [ENTRIES-1:0][DW-1:0] table_in,
    input  logic [AW-1:0]              sel,
    output logic [DW-1:0]              val
);
    assign val = table_in[sel];
endmodule

// File: rtl/rn_release_filter.sv
// Accepts a release only for a register that is in use but no longer mapped.
module rn_release_filter #(
    parameter int unsigned ARCH_REGS = 8,
    parameter int unsigned PHYS_REGS = 16,
    parameter int unsigned PW        = 4
) (
    input  logic [ARCH_REGS-1:0][PW-1:0] map_in,
    input  logic [PHYS_REGS-1:0]         free_vec,
    input  logic                         rel_valid,
    input  logic [PW-1:0]                rel_phys,
    output logic                         rel_ok
);
    logic [ARCH_REGS-1:0] hit;

    generate
        for (genvar g = 0; g < ARCH_REGS; g++) begin : g_cmp
            assign hit[g] = (map_in[g] == rel_phys);
        end
    endgenerate

    assign rel_ok = rel_valid && !free_vec[rel_phys] && (hit == '0);
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
    parameter  int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
    parameter  int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW        = $clog2(ARCH_REGS),
    localparam int unsigned PW        = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] src1_arch,
    input  logic [AW-1:0] src2_arch,
    input  logic [AW-1:0] dst_arch,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic          out_valid,
    output logic [PW-1:0] src1_phys,
    output logic [PW-1:0] src2_phys,
    output logic [PW-1:0] dst_phys,
    output logic [PW-1:0] old_phys
);
    localparam int unsigned NRD = 3;

    typedef struct packed {
        logic [ARCH_REGS-1:0][PW-1:0] map;
        logic [PHYS_REGS-1:0]         free;
        logic                         ov;
        logic [PW-1:0]                s1;
        logic [PW-1:0]                s2;
        logic [PW-1:0]                dp;
        logic [PW-1:0]                op;
    } rn_state_t;

    function automatic rn_state_t reset_state();
        rn_state_t r;
        r = '0;
        for (int i = 0; i < ARCH_REGS; i++) r.map[i] = PW'(i);
        for (int i = 0; i < PHYS_REGS; i++) r.free[i] = (i >= ARCH_REGS);
        return r;
    endfunction

    rn_state_t st_d, st_q;

    // map read ports: src1, src2, destination (old instance)
    logic [NRD-1:0][AW-1:0] rd_sel;
    logic [NRD-1:0][PW-1:0] rd_val;
    assign rd_sel[0] = src1_arch;
    assign rd_sel[1] = src2_arch;
    assign rd_sel[2] = dst_arch;

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            rn_map_read #(
                .ENTRIES (ARCH_REGS),
                .AW      (AW),
                .DW      (PW)
            ) rd_i (
                .table_in (st_q.map),
                .sel      (rd_sel[g]),
                .val      (rd_val[g])
            );
        end
    endgenerate

    logic          pick_found;
    logic [PW-1:0] pick_idx;

    rn_free_pick #(.N(PHYS_REGS)) pick_i (
        .free_vec (st_q.free),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    logic rel_ok;

    rn_release_filter #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .PW        (PW)
    ) relf_i (
        .map_in    (st_q.map),
        .free_vec  (st_q.free),
        .rel_valid (rel_valid),
        .rel_phys  (rel_phys),
        .rel_ok    (rel_ok)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (in_valid && pick_found) begin
            st_d.ov            = 1'b1;
            st_d.s1            = rd_val[0];
            st_d.s2            = rd_val[1];
            st_d.op            = rd_val[2];
            st_d.dp            = pick_idx;
            st_d.map[dst_arch] = pick_idx;
            st_d.free[pick_idx] = 1'b0;
        end
        // filtered release never names the register picked this cycle
        if (rel_ok) st_d.free[rel_phys] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    logic [PHYS_REGS-1:0] free_vec_q;
    assign free_vec_q = st_q.free;

    assign out_valid = st_q.ov;
    assign src1_phys = st_q.s1;
    assign src2_phys = st_q.s2;
    assign dst_phys  = st_q.dp;
    assign old_phys  = st_q.op;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter  int unsigned ARCH_REGS = 8,
    parameter  int unsigned PHYS_REGS = 16,
    localparam int unsigned AW        = $clog2(ARCH_REGS),
    localparam int unsigned PW        = $clog2(PHYS_REGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [AW-1:0]        src1_arch,
    input logic [AW-1:0]        dst_arch,
    input logic                 rel_valid,
    input logic [PW-1:0]        rel_phys,
    input logic                 out_valid,
    input logic [PW-1:0]        src1_phys,
    input logic [PW-1:0]        dst_phys,
    input logic [PW-1:0]        old_phys,
    input logic [PHYS_REGS-1:0] free_vec
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R10
    idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !in_valid |=> !out_valid);

    // R6
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && in_valid && (free_vec == '0) |=> !out_valid);

    // R3
    fresh_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && out_valid |-> dst_phys != old_phys);

    // R5
    self_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(in_valid && (src1_arch == dst_arch)) && out_valid
        |-> src1_phys == old_phys);

    // R9
    dup_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !in_valid && rel_valid && free_vec[rel_phys] |=> $stable(free_vec));

    // R7
    pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_vec) <= (PHYS_REGS - ARCH_REGS));
endmodule

bind rn_rename_top rn_rename_chk #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src1_arch (src1_arch),
    .dst_arch  (dst_arch),
    .rel_valid (rel_valid),
    .rel_phys  (rel_phys),
    .out_valid (out_valid),
    .src1_phys (src1_phys),
    .dst_phys  (dst_phys),
    .old_phys  (old_phys),
    .free_vec  (free_vec_q)
);

// File: tb/rn_rename_top_tb_top.sv
`timescale 1ns/1ps
module rn_rename_top_tb_top;
    localparam int NA = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] src1_arch = '0, src2_arch = '0, dst_arch = '0;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_phys = '0;
    logic       out_valid;
    logic [3:0] src1_phys, src2_phys, dst_phys, old_phys;

    always #2.5 clk = ~clk;

    rn_rename_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src1_arch(src1_arch), .src2_arch(src2_arch), .dst_arch(dst_arch),
        .rel_valid(rel_valid), .rel_phys(rel_phys),
        .out_valid(out_valid), .src1_phys(src1_phys), .src2_phys(src2_phys),
        .dst_phys(dst_phys), .old_phys(old_phys)
    );

    // behavioural reference
    int    m_map [NA];
    bit    m_free[NP];
    int    retq[$];
    bit    e_valid;
    int    e_s1, e_s2, e_dp, e_op;
    string prev_req = "R1";
    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 1'b0;

    function automatic bit is_mapped(int p);
        for (int i = 0; i < NA; i++) if (m_map[i] == p) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int free_count();
        int c = 0;
        for (int i = 0; i < NP; i++) c += m_free[i];
        return c;
    endfunction

    task automatic fail(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic compare();
        vectors++;
        if (out_valid !== e_valid) fail(prev_req, "out_valid", int'(out_valid), int'(e_valid));
        else if (e_valid) begin
            if (src1_phys !== 4'(e_s1)) fail(prev_req, "src1_phys", int'(src1_phys), e_s1);
            if (src2_phys !== 4'(e_s2)) fail(prev_req, "src2_phys", int'(src2_phys), e_s2);
            if (dst_phys  !== 4'(e_dp)) fail(prev_req, "dst_phys",  int'(dst_phys),  e_dp);
            if (old_phys  !== 4'(e_op)) fail(prev_req, "old_phys",  int'(old_phys),  e_op);
        end
    endtask

    // one cycle: check previous result, drive new inputs, advance model
    task automatic step(bit iv, int s1, int s2, int d, bit rv, int rp, string req);
        bit rel_ok;
        int pick;
        @(negedge clk);
        compare();
        in_valid  = iv;  src1_arch = 3'(s1); src2_arch = 3'(s2); dst_arch = 3'(d);
        rel_valid = rv;  rel_phys  = 4'(rp);
        rel_ok = rv && !m_free[rp] && !is_mapped(rp);
        e_valid = 1'b0;
        if (iv) begin
            pick = -1;
            for (int i = NP - 1; i >= 0; i--) if (m_free[i]) pick = i;
            if (pick >= 0) begin
                e_valid = 1'b1;
                e_s1 = m_map[s1]; e_s2 = m_map[s2]; e_op = m_map[d]; e_dp = pick;
                m_map[d] = pick; m_free[pick] = 1'b0;
                retq.push_back(e_op);
            end
        end
        if (rel_ok) m_free[rp] = 1'b1;
        prev_req = req;
    endtask

    task automatic idle(string req);
        step(1'b0, 0, 0, 0, 1'b0, 0, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        int p;
        for (int i = 0; i < NA; i++) m_map[i] = i;
        for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
        e_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, identity map visible through sources
        idle("R1");
        step(1, 0, 1, 0, 0, 0, "R1");
        step(1, 2, 3, 1, 0, 0, "R1");
        step(1, 4, 5, 2, 0, 0, "R2");
        step(1, 6, 7, 7, 0, 0, "R2");
        // R3: reading a freshly written arch register returns the new ID
        step(1, 0, 1, 3, 0, 0, "R3");
        // R5: source equals destination
        step(1, 3, 3, 3, 0, 0, "R5");
        step(1, 2, 7, 5, 0, 0, "R4");
        // R10: idle with junk on the IDs
        step(0, 7, 6, 4, 0, 0, "R10");
        step(0, 5, 1, 6, 0, 0, "R10");
        step(1, 4, 6, 6, 0, 0, "R4");
        // R6: pool now empty
        step(1, 1, 2, 0, 0, 0, "R6");
        step(1, 3, 4, 1, 0, 0, "R6");
        // R9: release a mapped register while empty, then try to rename
        step(0, 0, 0, 0, 1, m_map[2], "R9");
        step(1, 2, 2, 2, 0, 0, "R9");
        // R7: release a retired old ID, then allocate it
        p = retq.pop_front();
        step(0, 0, 0, 0, 1, p, "R7");
        step(1, 0, 5, 4, 0, 0, "R7");
        // R8: release and allocation in the same cycle with empty pool
        p = retq.pop_front();
        step(1, 1, 2, 3, 1, p, "R8");
        step(1, 1, 2, 3, 0, 0, "R8");
        // R8: one free, release plus allocation, then allocate again
        p = retq.pop_front();
        step(0, 0, 0, 0, 1, p, "R8");
        p = retq.pop_front();
        step(1, 3, 6, 0, 1, p, "R8");
        step(1, 0, 0, 6, 0, 0, "R8");
        // R9: release an already-free register twice, then allocate twice
        p = retq.pop_front();
        step(0, 0, 0, 0, 1, p, "R9");
        step(0, 0, 0, 0, 1, p, "R9");
        step(1, 5, 1, 1, 0, 0, "R9");
        step(1, 5, 1, 2, 0, 0, "R9");

        // random mix, pool kept near empty
        for (int n = 0; n < 600; n++) begin
            bit iv, rv;
            int rp;
            iv = ($urandom_range(0, 3) != 0);
            rv = 1'b0; rp = 0;
            if ($urandom_range(0, 7) == 0) begin
                rv = 1'b1; rp = m_map[$urandom_range(0, NA - 1)];
            end else if (retq.size() > 0 && $urandom_range(0, 2) != 0) begin
                rv = 1'b1; rp = retq.pop_front();
            end
            step(iv, $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
                 $urandom_range(0, NA - 1), rv, rp, (free_count() == 0) ? "R6" : "R3");
        end
        idle("R10");
        idle("R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule